// File: doc/BRIEF.md
# DMA Channel Register Slice

This block is the host-facing register file for one channel of a legacy-style DMA controller, together with a small transfer counter. Software writes single bytes through one write port, and a port selector picks the target register. The 16-bit address and 16-bit count registers are each loaded as two byte writes through the same port. A byte-pointer flip-flop chooses which half each byte lands in. The address port and the count port share this pointer, and a write to a separate port clears it. An 8-bit page register supplies the upper address bits. The mode byte is split into transfer fields, and a mask bit gates the channel.

Once the channel is programmed and unmasked, each device request is acknowledged in the same cycle. On the next clock edge the current address moves one step and the current count drops by one. When the count wraps from zero to all ones, the block raises terminal count. It then either reloads the current registers from the base registers, if auto-initialise is set, or masks the channel.

Top module: `dma_chan_slice`

## Requirements
- R1: A write of any data to port 5 clears the byte pointer, so the next address or count byte goes to the low half. Reset also clears the pointer.
- R2: Port 0 (address) and port 1 (count) share the byte pointer. A write to either port loads the half the pointer selects, low first and then high, and toggles the pointer. The other half is left unchanged.
- R3: A write to port 2 loads the page byte, which appears as bits 23:16 of `xfer_addr`. Bits 15:0 of `xfer_addr` are the current address.
- R4: The programmed count is the transfer length minus one: a count of N gives terminal count on acknowledge number N+1.
- R5: A write to port 4 (mode) with bits 1:0 equal to the channel number stores the mode fields. These are direction in bits 3:2 (01 = device to memory, 10 = memory to device, 00 = verify), auto-initialise in bit 4, address decrement in bit 5 (0 = increment) and transfer kind in bits 7:6 (01 = single).
- R6: A mode write whose direction field is 11 is ignored. A mode write or mask write whose bits 1:0 name another channel is also ignored.
- R7: A write to port 3 whose bits 1:0 match the channel sets the mask if bit 2 is 1 and clears it if bit 2 is 0. With channel 2, the value 6 masks and the value 2 unmasks.
- R8: Reset leaves the channel masked with terminal count low. A masked channel never asserts `dack`, and a request made while masked changes neither the address nor the count.
- R9: Each acknowledged request steps the current address by +1, or by -1 when decrement is set, and decrements the current count on the next edge. During the acknowledge, `mem_wr` is high for direction 01 and `mem_rd` is high for direction 10.
- R10: When an acknowledge finds the count at zero, `tc` is high for the following cycle and the count reads all ones. If auto-initialise is clear, the channel becomes masked at that same edge.
- R11: At terminal count with auto-initialise set, the current address and count reload from the base registers and the channel stays unmasked.
- R12: No request is acknowledged in a cycle that carries a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 3 | Register selector (0 addr, 1 count, 2 page, 3 mask, 4 mode, 5 pointer clear) |
| wr_data | input | 8 | Write byte |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Transfer acknowledge, same cycle as the granted request |
| mem_wr | output | 1 | Acknowledged transfer writes memory |
| mem_rd | output | 1 | Acknowledged transfer reads memory |
| tc | output | 1 | Terminal count, one cycle |
| xfer_addr | output | 24 | Page and current address |
| xfer_count | output | 16 | Current count |
| ch_masked | output | 1 | Channel mask state |
| xfer_dir | output | 2 | Stored direction field |
| auto_init | output | 1 | Stored auto-initialise bit |
| addr_down | output | 1 | Stored decrement bit |
| xfer_kind | output | 2 | Stored transfer kind |
| byte_hi | output | 1 | Byte pointer (1 = next byte goes to the high half) |

## Verification
Register writes take effect at the first rising edge after the write cycle. The bench presents each write on a falling edge and reads the result on the next falling edge. `dack`, `mem_wr` and `mem_rd` are combinational, so they are sampled one time unit after the request is driven, inside the same cycle. The address and count step at the edge that ends the acknowledge cycle. `tc` and the automatic mask appear on that same edge, so the bench checks them on the falling edge right after the final request and again one cycle later, to confirm the pulse has ended.

// File: rtl/dma_slice_pkg.sv
package dma_slice_pkg;
  localparam logic [2:0] PORT_ADDR   = 3'd0;
  localparam logic [2:0] PORT_COUNT  = 3'd1;
  localparam logic [2:0] PORT_PAGE   = 3'd2;
  localparam logic [2:0] PORT_MASK   = 3'd3;
  localparam logic [2:0] PORT_MODE   = 3'd4;
  localparam logic [2:0] PORT_PTRCLR = 3'd5;

  localparam logic [1:0] DIR_VERIFY   = 2'b00;
  localparam logic [1:0] DIR_TO_MEM   = 2'b01;
  localparam logic [1:0] DIR_FROM_MEM = 2'b10;
  localparam logic [1:0] DIR_ILLEGAL  = 2'b11;

  typedef struct packed {
    logic [1:0] kind;
    logic       down;
    logic       autoinit;
    logic [1:0] dir;
  } mode_t;

  function automatic mode_t unpack_mode(input logic [7:0] b);
    mode_t m;
    m.kind     = b[7:6];
    m.down     = b[5];
    m.autoinit = b[4];
    m.dir      = b[3:2];
    return m;
  endfunction
endpackage

// File: rtl/dma_base_regs.sv
module dma_base_regs
  import dma_slice_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_port,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] base_addr,
  output logic [2*DW-1:0] base_cnt,
  output logic [PW-1:0]   page,
  output logic            hi_ptr,
  output logic            addr_stb,
  output logic            cnt_stb
);
  localparam int LANES = 2;

  logic clr_stb, page_stb;

  assign addr_stb = wr_en && (wr_port == PORT_ADDR);
  assign cnt_stb  = wr_en && (wr_port == PORT_COUNT);
  assign clr_stb  = wr_en && (wr_port == PORT_PTRCLR);
  assign page_stb = wr_en && (wr_port == PORT_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n)                   hi_ptr <= 1'b0;
    else if (clr_stb)             hi_ptr <= 1'b0;
    else if (addr_stb || cnt_stb) hi_ptr <= ~hi_ptr;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_addr[ln*DW +: DW] <= '0;
        base_cnt[ln*DW +: DW]  <= '0;
      end else begin
        if (addr_stb && (hi_ptr == 1'(ln))) base_addr[ln*DW +: DW] <= wr_data;
        if (cnt_stb  && (hi_ptr == 1'(ln))) base_cnt[ln*DW +: DW]  <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        page <= '0;
    else if (page_stb) page <= wr_data[PW-1:0];
  end

  AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && !hi_ptr) |=> (base_addr[2*DW-1:DW] == $past(base_addr[2*DW-1:DW]))); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (!hi_ptr)); // R1
endmodule

// File: rtl/dma_mode_mask.sv
module dma_mode_mask
  import dma_slice_pkg::*;
#(
  parameter int CHW     = 2,
  parameter int CHAN_ID = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_port,
  input  logic [7:0] wr_data,
  input  logic       tc_mask_set,
  output mode_t      mode_q,
  output logic       masked
);
  localparam logic [CHW-1:0] MY_CH = CHW'(CHAN_ID);

  logic  ch_hit, mode_ok, mode_stb, mask_stb;
  mode_t mode_in;

  assign ch_hit   = (wr_data[CHW-1:0] == MY_CH);
  assign mode_in  = unpack_mode(wr_data);
  assign mode_ok  = (mode_in.dir != DIR_ILLEGAL);
  assign mode_stb = wr_en && (wr_port == PORT_MODE) && ch_hit && mode_ok;
  assign mask_stb = wr_en && (wr_port == PORT_MASK) && ch_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= '0;
    else if (mode_stb) mode_q <= mode_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           masked <= 1'b1;
    else if (tc_mask_set) masked <= 1'b1;
    else if (mask_stb)    masked <= wr_data[2];
  end

  AST_ILLEGAL_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == PORT_MODE && wr_data[3:2] == DIR_ILLEGAL) |=> $stable(mode_q)); // R6
  AST_FOREIGN_MASK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == PORT_MASK && !ch_hit && !tc_mask_set) |=> $stable(masked)); // R6
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic            addr_stb,
  input  logic            cnt_stb,
  input  logic            hi_ptr,
  input  logic [DW-1:0]   wr_data,
  input  logic [2*DW-1:0] base_addr,
  input  logic [2*DW-1:0] base_cnt,
  input  logic            auto_init,
  input  logic            addr_down,
  output logic [2*DW-1:0] cur_addr,
  output logic [2*DW-1:0] cur_cnt,
  output logic            wrap_evt,
  output logic            tc
);
  localparam int RW = 2 * DW;

  function automatic logic [RW-1:0] step_addr(input logic [RW-1:0] a, input logic down);
    return down ? (a - 1'b1) : (a + 1'b1);
  endfunction

  function automatic logic [RW-1:0] dec_count(input logic [RW-1:0] c);
    return c - 1'b1;
  endfunction

  logic reload;

  assign wrap_evt = ack && (cur_cnt == '0);
  assign reload   = wrap_evt && auto_init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      tc       <= 1'b0;
    end else begin
      tc <= wrap_evt;
      if (addr_stb)    cur_addr[hi_ptr*DW +: DW] <= wr_data;
      else if (reload) cur_addr <= base_addr;
      else if (ack)    cur_addr <= step_addr(cur_addr, addr_down);
      if (cnt_stb)     cur_cnt[hi_ptr*DW +: DW] <= wr_data;
      else if (reload) cur_cnt <= base_cnt;
      else if (ack)    cur_cnt <= dec_count(cur_cnt);
    end
  end

  AST_TC_COUNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_init) |-> (cur_cnt == '1)); // R10
  AST_TC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && auto_init) |-> (cur_addr == base_addr && cur_cnt == base_cnt)); // R11
  AST_ACK_STEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cur_cnt != '0 && !cnt_stb) |=> (cur_cnt == $past(cur_cnt) - 1'b1)); // R9
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_slice_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PW      = 8,
  parameter int CHW     = 2,
  parameter int CHAN_ID = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_port,
  input  logic [7:0]         wr_data,
  input  logic               dreq,
  output logic               dack,
  output logic               mem_wr,
  output logic               mem_rd,
  output logic               tc,
  output logic [2*DW+PW-1:0] xfer_addr,
  output logic [2*DW-1:0]    xfer_count,
  output logic               ch_masked,
  output logic [1:0]         xfer_dir,
  output logic               auto_init,
  output logic               addr_down,
  output logic [1:0]         xfer_kind,
  output logic               byte_hi
);
  localparam int RW = 2 * DW;

  logic [RW-1:0] base_addr, base_cnt, cur_addr;
  logic [PW-1:0] page;
  logic          addr_stb, cnt_stb, wrap_evt, tc_mask_set;
  mode_t         mode_q;

  dma_base_regs #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data[DW-1:0]), .base_addr(base_addr), .base_cnt(base_cnt),
    .page(page), .hi_ptr(byte_hi), .addr_stb(addr_stb), .cnt_stb(cnt_stb)
  );

  dma_mode_mask #(.CHW(CHW), .CHAN_ID(CHAN_ID)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .tc_mask_set(tc_mask_set), .mode_q(mode_q),
    .masked(ch_masked)
  );

  assign dack        = dreq && !ch_masked && !wr_en;
  assign tc_mask_set = wrap_evt && !mode_q.autoinit;

  dma_xfer_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .ack(dack), .addr_stb(addr_stb),
    .cnt_stb(cnt_stb), .hi_ptr(byte_hi), .wr_data(wr_data[DW-1:0]),
    .base_addr(base_addr), .base_cnt(base_cnt), .auto_init(mode_q.autoinit),
    .addr_down(mode_q.down), .cur_addr(cur_addr), .cur_cnt(xfer_count),
    .wrap_evt(wrap_evt), .tc(tc)
  );

  assign xfer_addr = {page, cur_addr};
  assign mem_wr    = dack && (mode_q.dir == DIR_TO_MEM);
  assign mem_rd    = dack && (mode_q.dir == DIR_FROM_MEM);
  assign xfer_dir  = mode_q.dir;
  assign auto_init = mode_q.autoinit;
  assign addr_down = mode_q.down;
  assign xfer_kind = mode_q.kind;

  AST_TC_MASKS_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_init) |-> ch_masked); // R10
  AST_AUTO_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && auto_init) |-> !ch_masked); // R11
  AST_MASKED_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_masked && !wr_en) |=> $stable(xfer_count)); // R8
endmodule

// File: tb/dma_chan_slice_bench.sv
module dma_chan_slice_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, dreq = 1'b0;
  logic [2:0]  wr_port = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        dack, mem_wr, mem_rd, tc, ch_masked, auto_init, addr_down, byte_hi;
  logic [23:0] xfer_addr;
  logic [15:0] xfer_count;
  logic [1:0]  xfer_dir, xfer_kind;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_slice u_dma_chan_slice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .dreq(dreq), .dack(dack), .mem_wr(mem_wr), .mem_rd(mem_rd), .tc(tc),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count), .ch_masked(ch_masked),
    .xfer_dir(xfer_dir), .auto_init(auto_init), .addr_down(addr_down),
    .xfer_kind(xfer_kind), .byte_hi(byte_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(output logic a, output logic mw, output logic mr);
    @(negedge clk); dreq = 1'b1; #1; a = dack; mw = mem_wr; mr = mem_rd;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic t_reset();
    dreq = 1'b1; #1;
    check("R8 reset mask", 32'(ch_masked), 1);
    check("R8 no ack when masked", 32'(dack), 0);
    check("R1 reset pointer", 32'(byte_hi), 0);
    check("R8 reset tc", 32'(tc), 0);
    dreq = 1'b0;
  endtask

  task automatic t_program();
    wr(3'd0, 8'hAA);
    check("R2 pointer after one byte", 32'(byte_hi), 1);
    wr(3'd5, 8'h77);
    check("R1 pointer cleared", 32'(byte_hi), 0);
    wr(3'd0, 8'h34); wr(3'd0, 8'h12); wr(3'd2, 8'h05);
    check("R3 page and address", 32'(xfer_addr), 32'h051234);
    wr(3'd1, 8'hCD); wr(3'd1, 8'hAB);
    check("R2 count low then high", 32'(xfer_count), 32'hABCD);
  endtask

  task automatic t_mode();
    wr(3'd4, 8'h56);
    check("R5 dir 0x56", 32'(xfer_dir), 1);
    check("R5 autoinit 0x56", 32'(auto_init), 1);
    check("R5 kind 0x56", 32'(xfer_kind), 1);
    check("R5 down 0x56", 32'(addr_down), 0);
    wr(3'd4, 8'h5A);
    check("R5 dir 0x5A", 32'(xfer_dir), 2);
    wr(3'd4, 8'h5E);
    check("R6 illegal dir ignored", 32'(xfer_dir), 2);
    wr(3'd4, 8'h65);
    check("R6 foreign channel mode ignored", 32'(addr_down), 0);
  endtask

  task automatic t_mask();
    wr(3'd3, 8'h02);
    check("R7 unmask with 2", 32'(ch_masked), 0);
    wr(3'd3, 8'h05);
    check("R6 foreign mask ignored", 32'(ch_masked), 0);
    wr(3'd3, 8'h06);
    check("R7 mask with 6", 32'(ch_masked), 1);
  endtask

  task automatic t_single_run();
    logic a, mw, mr;
    wr(3'd5, 8'h00); wr(3'd0, 8'h00); wr(3'd0, 8'h20);
    wr(3'd1, 8'h02); wr(3'd1, 8'h00); wr(3'd2, 8'h03);
    wr(3'd4, 8'h4A); wr(3'd3, 8'h02);
    pulse(a, mw, mr);
    check("R9 ack", 32'(a), 1);
    check("R9 mem_rd for dir 10", 32'(mr), 1);
    check("R9 no mem_wr for dir 10", 32'(mw), 0);
    check("R9 address +1", 32'(xfer_addr), 32'h032001);
    check("R9 count -1", 32'(xfer_count), 1);
    pulse(a, mw, mr);
    check("R4 no tc before length", 32'(tc), 0);
    pulse(a, mw, mr);
    check("R4 tc after count+1 acks", 32'(tc), 1);
    check("R10 count wraps", 32'(xfer_count), 32'hFFFF);
    check("R10 masked at tc", 32'(ch_masked), 1);
    check("R9 address after three", 32'(xfer_addr), 32'h032003);
    @(negedge clk);
    check("R10 tc one cycle", 32'(tc), 0);
    pulse(a, mw, mr);
    check("R8 masked request ignored", 32'(a), 0);
    check("R8 count held when masked", 32'(xfer_count), 32'hFFFF);
  endtask

  task automatic t_auto();
    logic a, mw, mr;
    wr(3'd5, 8'h00); wr(3'd0, 8'h00); wr(3'd0, 8'h01);
    wr(3'd1, 8'h01); wr(3'd1, 8'h00);
    wr(3'd4, 8'h56); wr(3'd3, 8'h02);
    pulse(a, mw, mr);
    check("R9 mem_wr for dir 01", 32'(mw), 1);
    pulse(a, mw, mr);
    check("R11 tc", 32'(tc), 1);
    check("R11 address reload", 32'(xfer_addr), 32'h030100);
    check("R11 count reload", 32'(xfer_count), 1);
    check("R11 stays unmasked", 32'(ch_masked), 0);
  endtask

  task automatic t_down_and_gate();
    logic a, mw, mr;
    wr(3'd4, 8'h66);
    pulse(a, mw, mr);
    check("R9 address decrement", 32'(xfer_addr), 32'h0300FF);
    @(negedge clk); wr_en = 1'b1; wr_port = 3'd2; wr_data = 8'h03; dreq = 1'b1; #1;
    check("R12 no ack during write", 32'(dack), 0);
    @(negedge clk); wr_en = 1'b0; dreq = 1'b0;
    check("R12 count unchanged", 32'(xfer_count), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_mode();
    t_mask();
    t_single_run();
    t_auto();
    t_down_and_gate();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule